// File: doc/BRIEF.md
# Registered Eight-Bit Arithmetic-Logic Unit

This block is an 8-bit arithmetic-logic unit with registers on both sides of the logic. On a rising clock edge it captures two operands, a 3-bit function select and a carry input. During the next cycle it computes one of twelve functions. At the following edge it stores the 8-bit result and a carry output. Inputs sampled at one edge therefore show up on the outputs just after the next edge. A new operation can be issued on every cycle.

When the top select bit is clear, the carry input is part of the opcode. The adder always forms A + Y + carry-in, where Y is zero, B, the inverse of B or all-ones. This gives eight arithmetic functions. The sum comes from a chain of identical 4-bit slices. Each slice resolves its internal carries with generate and propagate lookahead terms, and each slice passes its carry on to the slice above it. When the top select bit is set, a bitwise unit supplies the result instead, the carry input is ignored and the carry output is zero. A synchronous active-high reset clears every register.

Top module: `alu8_reg_core`

## Requirements
- R1: With sel[2]=0, the code {sel[1:0],cin} selects the arithmetic result: 000 gives A, 001 gives A+1, 010 gives A+B, 011 gives A+B+1, 100 gives A-B-1, 101 gives A-B, 110 gives A-1 and 111 gives A. All results are modulo 256.
- R2: With sel[2]=1, sel[1:0] selects the bitwise result: 00 gives A|B, 01 gives A^B, 10 gives A&B and 11 gives ~A.
- R3: With sel[2]=1, cin has no effect on the result or on the carry output.
- R4: For arithmetic codes, the carry output is bit 8 of A + Y + cin, where Y is 0x00 for sel[1:0]=00, B for 01, ~B for 10 and 0xFF for 11. For logic codes the carry output is 0.
- R5: Inputs present at rising edge k appear on the outputs after rising edge k+1. Between those two edges the outputs still hold the previous result.
- R6: When reset is high at a rising edge, the result and carry outputs become 0 after that edge. The first result after reset is released is 0, because the input registers hold the pass-A code with A=0.
- R7: Carries pass correctly across the 4-bit slice boundary and out of the top slice. For example, 0x0F+1 gives 0x10 with carry 0, and 0xFF+1 gives 0x00 with carry 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 8 | Operand A |
| b_in | input | 8 | Operand B |
| sel_in | input | 3 | Function select; bit 2 chooses the logic path |
| cin_in | input | 1 | Carry input, part of the opcode for arithmetic |
| f_out | output | 8 | Registered result |
| cout_out | output | 1 | Registered carry output |

## Verification
The assertions assume two things about the inputs. First, reset is held high for at least one rising edge before any check that depends on history. Second, operands, select and carry input have settled before each rising edge, so the two register stages see one consistent vector per cycle. The stimulus meets both conditions: it changes inputs only on falling edges and asserts reset only for whole cycles. The sweep covers all sixteen select and carry-in combinations. Each combination runs with the corner operands 0x00, 0xFF, 0x80 and 0x7F and with random pairs. At every step the bench checks the result and carry after the second edge, and checks that the previous result is still present after the first edge.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
   // Source of the adder's second operand, indexed by sel[1:0] on arithmetic codes
   typedef enum logic [1:0] {
      YSRC_ZERO = 2'b00,
      YSRC_B    = 2'b01,
      YSRC_NOTB = 2'b10,
      YSRC_ONES = 2'b11
   } ysrc_e;

   // Bitwise operation, indexed by sel[1:0] on logic codes
   typedef enum logic [1:0] {
      LOP_OR   = 2'b00,
      LOP_XOR  = 2'b01,
      LOP_AND  = 2'b10,
      LOP_NOTA = 2'b11
   } lop_e;
endpackage

// File: rtl/alu8_cla_slice.sv
module alu8_cla_slice #(
   parameter int W         = 4,
   parameter bit LOOKAHEAD = 1'b1
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         c_i,
   output logic [W-1:0] s_o,
   output logic         c_o
);
   logic [W-1:0] gen_w;
   logic [W-1:0] prop_w;
   logic [W:0]   cy;

   if (W < 1) begin : g_bad_width
      $error("alu8_cla_slice: W must be at least 1");
   end

   assign gen_w  = a_i & b_i;
   assign prop_w = a_i ^ b_i;

   if (LOOKAHEAD) begin : g_lookahead
      // Each carry is a flat sum of products of generate/propagate terms
      always_comb begin
         logic term;
         logic run;
         cy[0] = c_i;
         for (int i = 0; i < W; i++) begin
            term = 1'b0;
            run  = 1'b1;
            for (int j = i; j >= 0; j--) begin
               term = term | (run & gen_w[j]);
               run  = run & prop_w[j];
            end
            cy[i+1] = term | (run & c_i);
         end
      end
   end else begin : g_ripple
      always_comb begin
         cy[0] = c_i;
         for (int i = 0; i < W; i++) begin
            cy[i+1] = gen_w[i] | (prop_w[i] & cy[i]);
         end
      end
   end

   assign s_o = prop_w ^ cy[W-1:0];
   assign c_o = cy[W];
endmodule

// File: rtl/alu8_slice_chain.sv
module alu8_slice_chain #(
   parameter int DATA_W    = 8,
   parameter int SLICE_W   = 4,
   parameter bit LOOKAHEAD = 1'b1
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] y_i,
   input  logic              c_i,
   output logic [DATA_W-1:0] s_o,
   output logic              c_o
);
   localparam int NSLICE = DATA_W / SLICE_W;

   if ((DATA_W % SLICE_W) != 0) begin : g_bad_split
      $error("alu8_slice_chain: DATA_W must be a multiple of SLICE_W");
   end

   logic [NSLICE:0] link;
   assign link[0] = c_i;

   for (genvar k = 0; k < NSLICE; k++) begin : g_slice
      alu8_cla_slice #(
         .W         (SLICE_W),
         .LOOKAHEAD (LOOKAHEAD)
      ) u_slice (
         .a_i (a_i[k*SLICE_W +: SLICE_W]),
         .b_i (y_i[k*SLICE_W +: SLICE_W]),
         .c_i (link[k]),
         .s_o (s_o[k*SLICE_W +: SLICE_W]),
         .c_o (link[k+1])
      );
   end

   assign c_o = link[NSLICE];
endmodule

// File: rtl/alu8_operand_sel.sv
module alu8_operand_sel
   import alu8_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] b_i,
   input  ysrc_e             mode_i,
   output logic [DATA_W-1:0] y_o
);
   always_comb begin
      unique case (mode_i)
         YSRC_ZERO: y_o = '0;
         YSRC_B:    y_o = b_i;
         YSRC_NOTB: y_o = ~b_i;
         YSRC_ONES: y_o = '1;
         default:   y_o = '0;
      endcase
   end
endmodule

// File: rtl/alu8_bitwise.sv
module alu8_bitwise
   import alu8_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  lop_e              op_i,
   output logic [DATA_W-1:0] r_o
);
   always_comb begin
      unique case (op_i)
         LOP_OR:   r_o = a_i | b_i;
         LOP_XOR:  r_o = a_i ^ b_i;
         LOP_AND:  r_o = a_i & b_i;
         LOP_NOTA: r_o = ~a_i;
         default:  r_o = '0;
      endcase
   end
endmodule

// File: rtl/alu8_reg_core.sv
module alu8_reg_core
   import alu8_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int SLICE_W   = 4,
   parameter bit LOOKAHEAD = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] a_in,
   input  logic [DATA_W-1:0] b_in,
   input  logic [2:0]        sel_in,
   input  logic              cin_in,
   output logic [DATA_W-1:0] f_out,
   output logic              cout_out
);
   if (SLICE_W < 1 || DATA_W < SLICE_W) begin : g_bad_cfg
      $error("alu8_reg_core: need 1 <= SLICE_W <= DATA_W");
   end

   // Input register stage
   logic [DATA_W-1:0] a_q;
   logic [DATA_W-1:0] b_q;
   logic [2:0]        sel_q;
   logic              cin_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         a_q   <= '0;
         b_q   <= '0;
         sel_q <= '0;
         cin_q <= 1'b0;
      end else begin
         a_q   <= a_in;
         b_q   <= b_in;
         sel_q <= sel_in;
         cin_q <= cin_in;
      end
   end

   // Arithmetic path: A + Y + cin
   logic [DATA_W-1:0] y_w;
   logic [DATA_W-1:0] sum_w;
   logic              carry_w;
   logic [DATA_W-1:0] bit_w;

   alu8_operand_sel #(.DATA_W(DATA_W)) u_ysel (
      .b_i    (b_q),
      .mode_i (ysrc_e'(sel_q[1:0])),
      .y_o    (y_w)
   );

   alu8_slice_chain #(
      .DATA_W    (DATA_W),
      .SLICE_W   (SLICE_W),
      .LOOKAHEAD (LOOKAHEAD)
   ) u_adder (
      .a_i (a_q),
      .y_i (y_w),
      .c_i (cin_q),
      .s_o (sum_w),
      .c_o (carry_w)
   );

   // Logic path
   alu8_bitwise #(.DATA_W(DATA_W)) u_logic (
      .a_i  (a_q),
      .b_i  (b_q),
      .op_i (lop_e'(sel_q[1:0])),
      .r_o  (bit_w)
   );

   // Path select and output register stage
   logic [DATA_W-1:0] f_d;
   logic              c_d;
   assign f_d = sel_q[2] ? bit_w : sum_w;
   assign c_d = sel_q[2] ? 1'b0 : carry_w;

   always_ff @(posedge clk) begin
      if (rst) begin
         f_out    <= '0;
         cout_out <= 1'b0;
      end else begin
         f_out    <= f_d;
         cout_out <= c_d;
      end
   end

   // Assertions
   AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> (f_out == '0 && !cout_out)); // R6

   AST_LOGIC_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
      sel_q[2] |=> !cout_out); // R4

   AST_ARITH_SUM: assert property (@(posedge clk) disable iff (rst)
      !sel_q[2] |=> ({cout_out, f_out} ==
         $past({1'b0, a_q} + {1'b0, y_w} + (DATA_W+1)'(cin_q)))); // R1

   AST_PASS_A: assert property (@(posedge clk) disable iff (rst)
      ({sel_q, cin_q} == 4'b0000 || {sel_q, cin_q} == 4'b0111)
      |=> f_out == $past(a_q)); // R1

   AST_NOT_A: assert property (@(posedge clk) disable iff (rst)
      sel_q == 3'b111 |=> f_out == ~$past(a_q)); // R2

   AST_XOR_OP: assert property (@(posedge clk) disable iff (rst)
      sel_q == 3'b101 |=> f_out == ($past(a_q) ^ $past(b_q))); // R2
endmodule

// File: tb/alu8_reg_core_tb.sv
`timescale 1ns/1ps
module alu8_reg_core_tb_top;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] a_in = '0;
   logic [7:0] b_in = '0;
   logic [2:0] sel_in = '0;
   logic       cin_in = 1'b0;
   logic [7:0] f_out;
   logic       cout_out;

   int checks = 0;
   int errors = 0;
   logic [7:0] prev_f = '0;
   logic       prev_c = 1'b0;

   always #2 clk = ~clk;

   alu8_reg_core dut_i (
      .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
      .sel_in(sel_in), .cin_in(cin_in), .f_out(f_out), .cout_out(cout_out)
   );

   // Expected {carry, result} from the function tables (R1, R2, R4)
   function automatic logic [8:0] model(input logic [7:0] a, input logic [7:0] b,
                                        input logic [3:0] code);
      logic [7:0] f;
      logic [7:0] y;
      logic [8:0] wide;
      case (code)
         4'd0: f = a;
         4'd1: f = a + 8'd1;
         4'd2: f = a + b;
         4'd3: f = a + b + 8'd1;
         4'd4: f = a - b - 8'd1;
         4'd5: f = a - b;
         4'd6: f = a - 8'd1;
         4'd7: f = a;
         4'd8, 4'd9:   f = a | b;
         4'd10, 4'd11: f = a ^ b;
         4'd12, 4'd13: f = a & b;
         default:      f = ~a;
      endcase
      case (code[2:1])
         2'd0: y = 8'h00;
         2'd1: y = b;
         2'd2: y = ~b;
         default: y = 8'hFF;
      endcase
      wide = {1'b0, a} + {1'b0, y} + {8'd0, code[0]};
      return {code[3] ? 1'b0 : wide[8], f};
   endfunction

   task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic run(input logic [7:0] a, input logic [7:0] b, input logic [3:0] code);
      logic [8:0] exp;
      string tag;
      exp = model(a, b, code);
      tag = code[3] ? (code[0] ? "R2/R3" : "R2") : "R1/R4";
      @(negedge clk);
      a_in = a; b_in = b; sel_in = code[3:1]; cin_in = code[0];
      @(posedge clk); #1;
      check("R5 hold", {cout_out, f_out}, {prev_c, prev_f});
      @(posedge clk); #1;
      check(tag, {cout_out, f_out}, exp);
      prev_c = exp[8]; prev_f = exp[7:0];
   endtask

   initial begin
      #(4 * 150000);
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] corners [4];
      corners[0] = 8'h00; corners[1] = 8'hFF; corners[2] = 8'h80; corners[3] = 8'h7F;
      repeat (3) @(posedge clk);
      #1;
      check("R6 reset", {cout_out, f_out}, 9'h000);
      @(negedge clk);
      a_in = 8'h5A; b_in = 8'h33; sel_in = 3'b001; cin_in = 1'b0;
      rst = 1'b0;
      @(posedge clk); #1;
      check("R6 first result", {cout_out, f_out}, 9'h000);
      @(posedge clk); #1;
      check("R1 post reset", {cout_out, f_out}, model(8'h5A, 8'h33, 4'd2));
      prev_f = f_out; prev_c = cout_out;
      // Slice boundary carries
      run(8'h0F, 8'h00, 4'd1); // R7 expects 0x10 carry 0
      check("R7 nibble", {cout_out, f_out}, 9'h010);
      run(8'hFF, 8'h00, 4'd1); // R7 expects 0x00 carry 1
      check("R7 top", {cout_out, f_out}, 9'h100);
      run(8'h08, 8'h08, 4'd2);
      check("R7 mid", {cout_out, f_out}, 9'h010);
      // Full sweep over codes, corners and random operands
      for (int code = 0; code < 16; code++) begin
         for (int i = 0; i < 4; i++)
            for (int j = 0; j < 4; j++)
               run(corners[i], corners[j], 4'(code));
         for (int r = 0; r < 24; r++)
            run(8'($urandom), 8'($urandom), 4'(code));
      end
      // R3: same operands with both cin values on every logic code
      for (int op = 0; op < 4; op++) begin
         run(8'hC5, 8'h6A, {1'b1, 2'(op), 1'b0});
         run(8'hC5, 8'h6A, {1'b1, 2'(op), 1'b1});
         check("R3 cin ignored", {cout_out, f_out}, model(8'hC5, 8'h6A, {1'b1, 2'(op), 1'b0}));
      end
      // R6: reset in mid-stream clears outputs
      run(8'hF0, 8'h0F, 4'd2);
      @(negedge clk);
      rst = 1'b1;
      @(posedge clk); #1;
      check("R6 mid reset", {cout_out, f_out}, 9'h000);
      @(negedge clk);
      rst = 1'b0;
      @(posedge clk); #1;
      check("R6 after release", {cout_out, f_out}, 9'h000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule